// File: doc/BRIEF.md
# Descriptor-Chained Bus-Master DMA Engine

This block is a bus-master DMA sequencer that follows a table of descriptors held in memory. Software writes the table's base address into its own register. It then writes the control register with the direction bit and the start bit. The engine reads each descriptor as two 32-bit words through a simple memory read port. Word 0 is the buffer address and word 1 is the byte count. For each descriptor it hands one burst request to a data mover and waits for the mover to finish. It then steps to the next entry, 8 bytes further on, and continues until it has processed an entry whose address word carries the end-of-table flag.

A single chunk can be as large as 512 MB and may cross any 64 KB line, so the byte count is carried at the full 32-bit width. Software can abort a run by writing the stop bit, and it can hold the engine in reset with a control bit. Three conditions are recorded in sticky status bits, each cleared by writing a 1 to it: normal completion, error and device interrupt. A read-only busy bit shows that a run is in progress.

Register map, selected by `reg_addr`: 0 is control, 1 is status, 2 is the table base address.

Top module: `desc_dma_engine`

## Requirements
- R1: After reset, control and status read as 0, and neither `mem_req` nor `mv_req` is asserted.
- R2: Writing control with bit 0 = 1 and bit 1 = 0, while idle and with bit 7 clear, makes status bit 0 (busy) read 1 from the next cycle. The first two memory fetches go to base and base+4, and register 2 reads back the base that was written.
- R3: Bit 0 of descriptor word 0 is the end-of-table flag. The mover receives that word with bit 0 cleared, and it receives the full 32-bit word 1 as the length, including lengths of 512 MB and above 64 KB.
- R4: Control bit 2, sampled when the run starts, drives `mv_to_mem` for every descriptor of that run. A value of 1 means device to memory.
- R5: Descriptors are fetched at successive 8-byte strides, one mover request per descriptor. After the mover finishes the flagged entry, busy falls and status bit 6 (done) is set.
- R6: A descriptor whose length word is 0 sets status bit 2 (error) and returns the engine to idle. No mover request is issued for it, and done is not set.
- R7: Writing control with bit 1 = 1 while busy returns the engine to idle on the next cycle. `mv_req` drops and done is not set.
- R8: While control bit 7 is 1, start writes are ignored and no memory or mover request is issued. Control reads back bit 7.
- R9: Status bits 2, 4 and 6 are sticky and are cleared by writing 1 to them at register 1. If an event sets a bit in the same cycle that software clears it, the bit ends up set.
- R10: A pulse on `dev_irq` sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | AW | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, with `mem_rdata` valid in the same cycle |
| mem_rdata | input | 32 | Descriptor word read data |
| mv_req | output | 1 | Burst request to the data mover, held until `mv_done` |
| mv_addr | output | AW | Buffer address with the flag bit cleared |
| mv_len | output | LW | Byte count of the burst |
| mv_to_mem | output | 1 | 1 = device to memory, 0 = memory to device |
| mv_done | input | 1 | Mover completion pulse |
| dev_irq | input | 1 | Device interrupt event |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the completion of the final descriptor's burst and a software write that clears done. The bench watches for `mv_done` on the final entry and drives the status write-1-to-clear in that same cycle. It then expects done to read back as 1 with busy at 0. The second pair is a stop write that arrives while a burst is pending: the mover is held so that it never completes, the stop is written, and the bench expects busy low, `mv_req` low and done clear.

// File: rtl/desc_dma_engine.sv
module desc_dma_engine #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          mv_req,
  output logic [AW-1:0] mv_addr,
  output logic [LW-1:0] mv_len,
  output logic          mv_to_mem,
  input  logic          mv_done,
  input  logic          dev_irq
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);
  localparam logic [AW-1:0] DESC_STEP = AW'(8);

  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1, S_MOVE} st_t;
  st_t st;

  logic [AW-1:0] base_q, ptr_q, cur_addr;
  logic [LW-1:0] cur_len;
  logic          last_q, dir_q, rw_bit, rst_bit;
  logic          err_q, dev_q, done_q;

  wire busy     = st != S_IDLE;
  wire wr_ctl   = reg_wr && reg_addr == 2'd0;
  wire wr_sts   = reg_wr && reg_addr == 2'd1;
  wire wr_base  = reg_wr && reg_addr == 2'd2;
  wire hold     = rst_bit || (wr_ctl && reg_wdata[7]);
  wire stop_now = wr_ctl && reg_wdata[1] && busy;
  wire go       = wr_ctl && reg_wdata[0] && !reg_wdata[1] && !hold && !busy;
  wire kill     = stop_now || hold;
  wire zero_len = st == S_W1 && mem_ack && mem_rdata[LW-1:0] == '0;
  wire err_set  = zero_len && !kill;
  wire done_set = st == S_MOVE && mv_done && last_q && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0; ptr_q <= '0; cur_addr <= '0; cur_len <= '0;
      last_q <= 1'b0; dir_q <= 1'b0; rw_bit <= 1'b0; rst_bit <= 1'b0;
      err_q <= 1'b0; dev_q <= 1'b0; done_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        rw_bit  <= reg_wdata[2];
        rst_bit <= reg_wdata[7];
      end
      if (wr_base) base_q <= reg_wdata[AW-1:0];
      case (st)
        S_IDLE: if (go) begin
          st    <= S_W0;
          ptr_q <= base_q;
          dir_q <= reg_wdata[2];
        end
        S_W0: if (mem_ack) begin
          cur_addr <= mem_rdata[AW-1:0];
          last_q   <= mem_rdata[0];
          st       <= S_W1;
        end
        S_W1: if (mem_ack) begin
          cur_len <= mem_rdata[LW-1:0];
          st      <= zero_len ? S_IDLE : S_MOVE;
        end
        S_MOVE: if (mv_done) begin
          if (last_q) st <= S_IDLE;
          else begin
            ptr_q <= ptr_q + DESC_STEP;
            st    <= S_W0;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (kill) st <= S_IDLE;
      err_q  <= err_set  | (err_q  & ~(wr_sts & reg_wdata[2]));
      dev_q  <= dev_irq  | (dev_q  & ~(wr_sts & reg_wdata[4]));
      done_q <= done_set | (done_q & ~(wr_sts & reg_wdata[6]));
    end
  end

  assign mem_req   = st == S_W0 || st == S_W1;
  assign mem_addr  = (st == S_W1) ? ptr_q + WORD_STEP : ptr_q;
  assign mv_req    = st == S_MOVE;
  assign mv_addr   = {cur_addr[AW-1:1], 1'b0};
  assign mv_len    = cur_len;
  assign mv_to_mem = dir_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {24'd0, rst_bit, 4'd0, rw_bit, 1'b0, busy};
      2'd1:    reg_rdata = {25'd0, done_q, 1'b0, dev_q, 1'b0, err_q, 1'b0, busy};
      2'd2:    reg_rdata = 32'(base_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  // R1: the fetch port and the mover port are never requested together
  a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mv_req));

  // R2: an accepted start makes the engine busy on the next cycle
  a_r2_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_ctl && reg_wdata[0] && !reg_wdata[1] && !reg_wdata[7] && !rst_bit)
    |=> (busy && mem_req));

  // R3: the flag bit never reaches the mover address
  a_r3_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> !mv_addr[0]);

  // R5: the final burst completing ends the run with done set
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && mv_done && last_q && !kill) |=> (done_q && !busy));

  // R6: a zero length word ends the run with an error and no burst
  a_r6_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_W1 && mem_ack && mem_rdata[LW-1:0] == '0 && !kill) |=> (err_q && !mv_req && !busy));

  // R7: a stop while busy idles the engine next cycle
  a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctl && reg_wdata[1]) |=> (!busy && !mv_req && !mem_req));

  // R8: held in reset, the engine issues no request
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |-> (!mem_req && !mv_req));
endmodule

// File: tb/sim_desc_dma_engine.sv
module sim_desc_dma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = 32'd0;
  logic mv_req, mv_to_mem, mv_done = 1'b0;
  logic [31:0] mv_addr, mv_len;
  logic dev_irq = 1'b0;

  int errors = 0, checks = 0;
  logic [31:0] mem [0:63];
  logic [31:0] flog [0:15];
  logic [31:0] la [0:15], ll [0:15];
  logic ld [0:15];
  int nf = 0, nreq = 0, mcnt = 0, mv_dly = 2;
  logic mv_hang = 1'b0;

  always #2.5 clk = ~clk;

  desc_dma_engine u0 (.*);

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      flog[nf % 16] <= mem_addr;
      nf <= nf + 1;
    end
    if (mv_done) mv_done <= 1'b0;
    else if (mv_req && !mv_hang) begin
      if (mcnt >= mv_dly) begin
        mv_done <= 1'b1;
        la[nreq % 16] <= mv_addr;
        ll[nreq % 16] <= mv_len;
        ld[nreq % 16] <= mv_to_mem;
        nreq <= nreq + 1;
        mcnt <= 0;
      end else mcnt <= mcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 400; k++) begin
      rd(2'd1, v);
      if (!v[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] e_addr(input int i);
    return 32'h2000_0000 * i + 32'h0000_FFF4 + (i << 4);
  endfunction

  function automatic logic [31:0] e_len(input int i);
    return (i == 0) ? 32'h2000_0000 : 32'h0001_0004 * i;
  endfunction

  task automatic run_table(input int n, input logic dir);
    logic [31:0] v;
    int f0, r0;
    for (int i = 0; i < n; i++) begin
      mem[16 + 2*i]     = e_addr(i) | ((i == n-1) ? 32'd1 : 32'd0);
      mem[16 + 2*i + 1] = e_len(i);
    end
    f0 = nf; r0 = nreq;
    wr(2'd2, 32'h40);
    rd(2'd2, v); chk("R2 base readback", v, 32'h40);
    wr(2'd0, {29'd0, dir, 2'b01});
    rd(2'd1, v); chk("R2 busy after start", {31'd0, v[0]}, 32'd1);
    wait_idle();
    chk("R5 descriptor count", nreq - r0, n);
    chk("R2 first fetch", flog[f0 % 16], 32'h40);
    chk("R2 second fetch", flog[(f0+1) % 16], 32'h44);
    chk("R5 fetch count", nf - f0, 2*n);
    for (int i = 0; i < n; i++) begin
      chk("R5 stride", flog[(f0 + 2*i) % 16], 32'h40 + 8*i);
      chk("R3 mover address", la[(r0+i) % 16], e_addr(i));
      chk("R3 mover length", ll[(r0+i) % 16], e_len(i));
      chk("R4 direction", {31'd0, ld[(r0+i) % 16]}, {31'd0, dir});
    end
    rd(2'd1, v); chk("R5 done set, idle", v, 32'h40);
    wr(2'd1, 32'h54);
    rd(2'd1, v); chk("R9 cleared", v, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 control reset", v, 32'h0);
    rd(2'd1, v); chk("R1 status reset", v, 32'h0);
    chk("R1 no requests", {30'd0, mem_req, mv_req}, 32'h0);

    for (int n = 1; n <= 4; n++)
      for (int d = 0; d < 2; d++) run_table(n, d[0]);

    // R6 zero length
    mem[16] = 32'h0000_1000; mem[17] = 32'h0;
    r0 = nreq;
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd1, v); chk("R6 error, no done", v, 32'h04);
    chk("R6 no burst", nreq - r0, 0);
    wr(2'd1, 32'h04);

    // R7 stop while burst pending
    mem[16] = 32'h0000_2000; mem[17] = 32'h100;
    mem[18] = 32'h0000_3001; mem[19] = 32'h100;
    mv_hang = 1'b1;
    wr(2'd0, 32'h1);
    for (int k = 0; k < 50 && !mv_req; k++) @(negedge clk);
    chk("R7 burst pending", {31'd0, mv_req}, 32'd1);
    wr(2'd0, 32'h2);
    chk("R7 mover released", {31'd0, mv_req}, 32'd0);
    rd(2'd1, v); chk("R7 idle, no done", v, 32'h0);
    mv_hang = 1'b0;

    // R8 engine held
    wr(2'd0, 32'h81);
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R8 start ignored", v, 32'h0);
    chk("R8 no requests", {30'd0, mem_req, mv_req}, 32'h0);
    rd(2'd0, v); chk("R8 control readback", v, 32'h80);
    wr(2'd0, 32'h0);

    // R10 device interrupt
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    rd(2'd1, v); chk("R10 devint sticky", v, 32'h10);
    wr(2'd1, 32'h01);
    rd(2'd1, v); chk("R9 busy write ignored", v, 32'h10);
    wr(2'd1, 32'h10);
    rd(2'd1, v); chk("R9 devint cleared", v, 32'h0);

    // R9 set beats clear in the same cycle
    mem[16] = 32'h0000_4001; mem[17] = 32'h20;
    mv_dly = 3;
    wr(2'd0, 32'h1);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #1;
      if (mv_done) break;
    end
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h40;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd1, v); chk("R9 set wins over clear", v, 32'h40);
    wr(2'd1, 32'h40);
    rd(2'd1, v); chk("R9 later clear", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule